// File: doc/BRIEF.md
# Priority Region Access Checker

This block decides, in the same cycle as the request, whether an instruction fetch or a data load/store may proceed. Software fills two separate tables of address windows, one for fetches and one for data accesses. Each window has a base, an exclusive limit, a permission field and a cacheable flag. Windows may overlap. When several windows cover an address, the one with the smallest index governs the access on its own. It supplies both the permission decision and the cacheability attribute.

Because the smallest index wins, a small no-access window can be placed inside a wider permissive one with a smaller index. This makes a guard hole, for example between a downward-growing stack and an upward-growing heap. An access that lands in the hole is denied and raises a fault pulse, even though the wider window would allow it. The unit leaves reset switched off, and in that state everything passes. Software switches checking on or off through a control register.

Top module: `region_guard`

## Requirements
- R1: After reset the unit is disabled. While disabled, every access gives rsp_allow=1 and rsp_cacheable=1, and rsp_fault stays 0.
- R2: A configuration write with cfg_addr[1:0]=3 sets the enable state to cfg_wdata[0], whatever the other address bits are. The new state applies from the cycle after the write.
- R3: A window matches an address when base <= address < limit. The limit itself is outside the window, and a window whose limit is not above its base matches nothing.
- R4: When several windows of the consulted table match, only the matching window with the smallest index decides whether the access is allowed.
- R5: While enabled, rsp_cacheable equals attribute bit 4 of the deciding window. This holds even when the access is denied.
- R6: A window with no permission bits set denies every access that lands in it and raises rsp_fault. This holds even when a window with a larger index that also covers the address would allow the access.
- R7: A fetch (req_fetch=1) is checked only against the instruction table. A load or store is checked only against the data table.
- R8: In the data table, attribute bits [3:0] are: bit 0 supervisor read, bit 1 supervisor write, bit 2 user read, bit 3 user write. A store has req_write=1 and a user-mode access has req_user=1.
- R9: In the instruction table, attribute bit 0 allows supervisor fetch and bit 1 allows user fetch. Bits 3:2 have no effect.
- R10: While enabled, an access that matches no window of its table is denied, reported non-cacheable, and raises rsp_fault.
- R11: rsp_fault is 1 exactly when req_valid=1, the unit is enabled and the access is denied. With req_valid=0 it stays 0.
- R12: cfg_addr holds the field in bits [1:0] (0 base, 1 limit, 2 attribute), the window index in the bits above those, and the table select in the top bit (0 instruction, 1 data). A write changes lookups from the next cycle on. A request in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (6) | Table select, window index, field |
| cfg_wdata | input | ADDR_W (32) | Write data |
| req_valid | input | 1 | Access request present |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_write | input | 1 | Store when 1, load when 0 (data only) |
| req_user | input | 1 | User mode when 1, supervisor when 0 |
| req_addr | input | ADDR_W (32) | Access address |
| rsp_allow | output | 1 | Access permitted |
| rsp_cacheable | output | 1 | Cacheability of the access |
| rsp_fault | output | 1 | Violation pulse |

## Verification
Random windows are packed into a small address space, so overlaps, empty windows and windows that share edges occur often. Random addresses across that space then compare the smallest-index choice against a second window that covers the same address.

Directed cases cover several points:
- Addresses just below the base, at the base, at limit-1 and at the limit, which separate inclusive from exclusive bounds.
- A guard hole inside a permissive window.
- A read-only window over a writable one, which separates a correct priority from an OR of permissions.
- A fetch and a load aimed at the same address, which shows that the two tables stay separate.
- Every combination of mode and direction, which pins down each permission bit.
- A write and a request in the same cycle, which fixes when a new setting takes effect.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  localparam int PERM_W    = 4;
  localparam int ATTR_W    = 5;
  localparam int CACHE_BIT = 4;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_ATTR  = 2'd2,
    FLD_CTRL  = 2'd3
  } cfg_field_e;

  // data permission: [0] sup read, [1] sup write, [2] user read, [3] user write
  function automatic logic data_perm_ok(logic [PERM_W-1:0] p, logic user, logic wr);
    logic ok;
    case ({user, wr})
      2'b00:   ok = p[0];
      2'b01:   ok = p[1];
      2'b10:   ok = p[2];
      default: ok = p[3];
    endcase
    return ok;
  endfunction

  // fetch permission: [0] sup execute, [1] user execute
  function automatic logic fetch_perm_ok(logic [PERM_W-1:0] p, logic user);
    return user ? p[1] : p[0];
  endfunction

endpackage

// File: rtl/region_table.sv
module region_table
  import region_guard_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int IW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  cfg_field_e                 wr_field,
  input  logic [AW-1:0]              wr_data,
  input  logic [AW-1:0]              addr,
  output logic [N-1:0]               match_o,
  output logic [N-1:0][PERM_W-1:0]   perm_o,
  output logic [N-1:0]               cache_o
);

  function automatic logic in_window(logic [AW-1:0] base, logic [AW-1:0] lim,
                                     logic [AW-1:0] a);
    return (a >= base) && (a < lim);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     limit_q;
    logic [ATTR_W-1:0] attr_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        attr_q  <= '0;
      end else if (sel) begin
        case (wr_field)
          FLD_BASE:  base_q  <= wr_data;
          FLD_LIMIT: limit_q <= wr_data;
          FLD_ATTR:  attr_q  <= wr_data[ATTR_W-1:0];
          default:   ;
        endcase
      end
    end

    assign match_o[g] = in_window(base_q, limit_q, addr);
    assign perm_o[g]  = attr_q[PERM_W-1:0];
    assign cache_o[g] = attr_q[CACHE_BIT];
  end

endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  match_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IW'(i);
    end
    hit_o   = |match_i;
    grant_o = '0;
    if (hit_o) grant_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_IREG = 8,
  parameter int N_DREG = 8,
  localparam int IW_I  = (N_IREG > 1) ? $clog2(N_IREG) : 1,
  localparam int IW_D  = (N_DREG > 1) ? $clog2(N_DREG) : 1,
  localparam int IDX_W = (IW_I > IW_D) ? IW_I : IW_D,
  localparam int CFG_AW = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_allow,
  output logic              rsp_cacheable,
  output logic              rsp_fault
);

  cfg_field_e cfg_field;
  logic       tbl_is_data;
  logic       enable_q;

  assign cfg_field   = cfg_field_e'(cfg_addr[1:0]);
  assign tbl_is_data = cfg_addr[CFG_AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                             enable_q <= 1'b0;
    else if (cfg_we && cfg_field == FLD_CTRL) enable_q <= cfg_wdata[0];
  end

  logic                          i_wr, d_wr;
  logic [N_IREG-1:0]             i_match, i_grant, i_cache;
  logic [N_DREG-1:0]             d_match, d_grant, d_cache;
  logic [N_IREG-1:0][PERM_W-1:0] i_perm;
  logic [N_DREG-1:0][PERM_W-1:0] d_perm;
  logic [IW_I-1:0]               i_idx;
  logic [IW_D-1:0]               d_idx;
  logic                          i_hit, d_hit;

  assign i_wr = cfg_we && (cfg_field != FLD_CTRL) && !tbl_is_data;
  assign d_wr = cfg_we && (cfg_field != FLD_CTRL) &&  tbl_is_data;

  region_table #(.N(N_IREG), .AW(ADDR_W), .IW(IW_I)) u_itab (
    .clk, .rst_n,
    .wr_en(i_wr), .wr_idx(cfg_addr[IW_I+1:2]), .wr_field(cfg_field),
    .wr_data(cfg_wdata), .addr(req_addr),
    .match_o(i_match), .perm_o(i_perm), .cache_o(i_cache)
  );

  region_table #(.N(N_DREG), .AW(ADDR_W), .IW(IW_D)) u_dtab (
    .clk, .rst_n,
    .wr_en(d_wr), .wr_idx(cfg_addr[IW_D+1:2]), .wr_field(cfg_field),
    .wr_data(cfg_wdata), .addr(req_addr),
    .match_o(d_match), .perm_o(d_perm), .cache_o(d_cache)
  );

  lowest_pick #(.N(N_IREG), .IW(IW_I)) u_ipick (
    .match_i(i_match), .grant_o(i_grant), .idx_o(i_idx), .hit_o(i_hit)
  );

  lowest_pick #(.N(N_DREG), .IW(IW_D)) u_dpick (
    .match_i(d_match), .grant_o(d_grant), .idx_o(d_idx), .hit_o(d_hit)
  );

  logic              win_hit, win_cache, perm_ok, check_allow;
  logic [PERM_W-1:0] win_perm;

  assign win_hit   = req_fetch ? i_hit           : d_hit;
  assign win_perm  = req_fetch ? i_perm[i_idx]   : d_perm[d_idx];
  assign win_cache = req_fetch ? i_cache[i_idx]  : d_cache[d_idx];
  assign perm_ok   = req_fetch ? fetch_perm_ok(win_perm, req_user)
                               : data_perm_ok(win_perm, req_user, req_write);
  assign check_allow = win_hit && perm_ok;

  assign rsp_allow     = !enable_q || check_allow;
  assign rsp_cacheable = !enable_q || (win_hit && win_cache);
  assign rsp_fault     = req_valid && enable_q && !check_allow;

endmodule

// File: rtl/region_guard_checker.sv
module region_guard_checker #(
  parameter int N_IREG = 8,
  parameter int N_DREG = 8,
  parameter int CFG_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              req_valid,
  input logic              req_fetch,
  input logic              rsp_allow,
  input logic              rsp_cacheable,
  input logic              rsp_fault,
  input logic              enable_q,
  input logic [N_IREG-1:0] i_match,
  input logic [N_IREG-1:0] i_grant,
  input logic [N_DREG-1:0] d_match,
  input logic [N_DREG-1:0] d_grant
);

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !enable_q);

  assert_disabled_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> (rsp_allow && rsp_cacheable && !rsp_fault));

  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr[1:0] == 2'd3) |=> (enable_q == $past(cfg_wdata[0])));

  assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(i_grant) && $onehot0(d_grant));

  assert_winner_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((i_grant & ~i_match) == '0) && ((d_grant & ~d_match) == '0) &&
    ((i_grant != '0) == (i_match != '0)) && ((d_grant != '0) == (d_match != '0)));

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((i_grant - N_IREG'(1)) & i_match) == '0 || i_grant == '0) &&
    (((d_grant - N_DREG'(1)) & d_match) == '0 || d_grant == '0));

  assert_nomatch_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && req_valid && (req_fetch ? (i_match == '0) : (d_match == '0)))
    |-> (rsp_fault && !rsp_allow && !rsp_cacheable));

  assert_fault_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (req_valid && enable_q && !rsp_allow));

endmodule

bind region_guard region_guard_checker #(
  .N_IREG(N_IREG), .N_DREG(N_DREG), .CFG_AW(CFG_AW)
) u_chk (
  .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .req_valid, .req_fetch,
  .rsp_allow, .rsp_cacheable, .rsp_fault, .enable_q,
  .i_match, .i_grant, .d_match, .d_grant
);

// File: tb/region_guard_bench.sv
module region_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_allow, rsp_cacheable, rsp_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_guard u_region_guard (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .req_valid, .req_fetch, .req_write, .req_user, .req_addr,
    .rsp_allow, .rsp_cacheable, .rsp_fault
  );

  // bench model: [0] instruction, [1] data
  int unsigned m_base [2][N];
  int unsigned m_lim  [2][N];
  bit [4:0]    m_attr [2][N];
  bit          m_en;

  function automatic void predict(bit f, bit w, bit u, bit v, int unsigned a,
                                  output bit ea, output bit ec, output bit ef);
    int t = f ? 0 : 1;
    int win = -1;
    bit ok;
    for (int i = N - 1; i >= 0; i--)
      if (m_base[t][i] <= a && a < m_lim[t][i]) win = i;
    if (!m_en) begin
      ea = 1; ec = 1; ef = 0;
      return;
    end
    if (win < 0) begin
      ok = 0; ec = 0;
    end else begin
      ec = m_attr[t][win][4];
      if (f) ok = m_attr[t][win][u ? 1 : 0];
      else   ok = m_attr[t][win][(u ? 2 : 0) + (w ? 1 : 0)];
    end
    ea = ok;
    ef = v && !ok;
  endfunction

  task automatic check(string tag, bit ea, bit ec, bit ef);
    checks++;
    if (rsp_allow !== ea || rsp_cacheable !== ec || rsp_fault !== ef) begin
      fails++;
      $display("FAIL %s: allow/cache/fault got %b%b%b expected %b%b%b addr=%0h",
               tag, rsp_allow, rsp_cacheable, rsp_fault, ea, ec, ef, req_addr);
    end
  endtask

  task automatic cfg_write(bit tbl, int idx, int field, int unsigned d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {tbl, 3'(idx), 2'(field)}; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 0;
    case (field)
      0: m_base[tbl][idx] = d;
      1: m_lim[tbl][idx]  = d;
      2: m_attr[tbl][idx] = d[4:0];
      default: m_en = d[0];
    endcase
  endtask

  task automatic set_region(bit tbl, int idx, int unsigned b, int unsigned l, bit [4:0] at);
    cfg_write(tbl, idx, 0, b);
    cfg_write(tbl, idx, 1, l);
    cfg_write(tbl, idx, 2, 32'(at));
  endtask

  task automatic probe(string tag, bit f, bit w, bit u, bit v, int unsigned a);
    bit ea, ec, ef;
    @(negedge clk);
    req_fetch = f; req_write = w; req_user = u; req_valid = v; req_addr = a;
    #(CLK_PERIOD/4);
    predict(f, w, u, v, a, ea, ec, ef);
    check(tag, ea, ec, ef);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ea, ec, ef;
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        m_base[t][i] = 0; m_lim[t][i] = 0; m_attr[t][i] = 0;
      end
    m_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: disabled after reset
    probe("R1 reset fetch", 1, 0, 1, 1, 32'h40);
    probe("R1 reset store", 0, 1, 1, 1, 32'h1234);

    // R2: programmed but disabled still passes, then enable
    set_region(1, 3, 32'h100, 32'h200, 5'b1_1111);
    probe("R2 disabled", 0, 1, 1, 1, 32'h300);
    cfg_write(1, 5, 3, 1);  // control via arbitrary table/index
    probe("R2 enabled nomatch", 0, 1, 1, 1, 32'h300);

    // R3 / R10: window edges
    probe("R10 below base", 0, 0, 0, 1, 32'hFF);
    probe("R3 at base", 0, 0, 0, 1, 32'h100);
    probe("R3 limit-1", 0, 1, 1, 1, 32'h1FF);
    probe("R3 at limit", 0, 0, 0, 1, 32'h200);

    // R6 / R5: guard hole, not cacheable
    set_region(1, 1, 32'h180, 32'h190, 5'b0_0000);
    probe("R6 hole", 0, 0, 0, 1, 32'h185);
    probe("R5 outer cacheable", 0, 0, 0, 1, 32'h195);

    // R4 / R5: read-only supervisor window over writable one
    set_region(1, 0, 32'h1A0, 32'h1C0, 5'b0_0001);
    probe("R4 store denied", 0, 1, 0, 1, 32'h1B0);
    probe("R4 load allowed", 0, 0, 0, 1, 32'h1B0);
    probe("R5 winner cache", 0, 0, 0, 1, 32'h1BF);

    // R8: each data permission bit
    set_region(1, 2, 32'h400, 32'h500, 5'b1_0100);
    probe("R8 user read", 0, 0, 1, 1, 32'h410);
    probe("R8 user write", 0, 1, 1, 1, 32'h410);
    probe("R8 sup read", 0, 0, 0, 1, 32'h410);
    probe("R8 sup write", 0, 1, 0, 1, 32'h410);

    // R7 / R9: separate tables, execute bits
    probe("R7 fetch no itab", 1, 0, 0, 1, 32'h150);
    set_region(0, 2, 32'h100, 32'h200, 5'b0_1101);
    probe("R9 sup fetch", 1, 0, 0, 1, 32'h150);
    probe("R9 user fetch", 1, 0, 1, 1, 32'h150);
    set_region(0, 4, 32'h600, 32'h700, 5'b1_0011);
    probe("R7 load uses dtab", 0, 0, 0, 1, 32'h650);
    probe("R7 fetch uses itab", 1, 0, 1, 1, 32'h650);

    // R11: no fault without a request
    probe("R11 idle", 0, 1, 1, 0, 32'h185);

    // R12: same-cycle write sees old setting, next cycle new
    @(negedge clk);
    req_fetch = 0; req_write = 0; req_user = 0; req_valid = 1; req_addr = 32'h420;
    cfg_we = 1; cfg_addr = {1'b1, 3'd2, 2'd2}; cfg_wdata = 32'h0;
    #(CLK_PERIOD/4);
    predict(0, 0, 0, 1, 32'h420, ea, ec, ef);
    check("R12 same cycle old", ea, ec, ef);
    @(posedge clk);
    #1 cfg_we = 0;
    m_attr[1][2] = 0;
    probe("R12 next cycle new", 0, 0, 0, 1, 32'h420);

    // random overlapping windows
    for (int round = 0; round < 6; round++) begin
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < N; i++) begin
          int unsigned b = $urandom % 200;
          set_region(t[0], i, b, b + ($urandom % 80), 5'($urandom));
        end
      if (round == 5) cfg_write(0, 0, 3, 0);
      for (int k = 0; k < 300; k++)
        probe(round == 5 ? "R2 random disabled" : "R4 random",
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              $urandom % 300);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule